// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Core

This block is a synthesizable, scaled-down model of a synchronous SRAM with separate read and write data ports. Every access moves two words. Both edges of the input clock are represented by one double-rate clock `clk` and an internal phase bit. That bit is exported as `k_phase`. When it is high, the coming `clk` edge stands for a rising edge of the true input clock, called a K edge here. When it is low, the coming edge stands for the complementary clock, called a K# edge. After reset the first edge is a K edge, and the two kinds then alternate.

Read and write commands are sampled only on K edges and may be accepted on the same edge. A read registers its address on the K edge that carries the command. A write takes its first data word on that same K edge, and its address and second data word on the following K# edge. The burst is fixed at two words in sequential order. The burst address is the registered address with its least significant bit replaced by 0 for the first word and by 1 for the second. The read side has no tri-state pins: `rdata_oe` marks when the data is driven, and `rdata` reads as zero otherwise.

Two state machines do the work. The read output machine has states RD_DESEL, RD_BEAT0 and RD_BEAT1. On a K edge it goes from RD_DESEL or RD_BEAT1 to RD_BEAT0 when a read is pending, and to RD_DESEL otherwise. On the next edge it always goes from RD_BEAT0 to RD_BEAT1. It stays in RD_DESEL on K# edges. The write machine has states WR_IDLE, WR_ADDR and WR_BEAT1. On a K edge it goes from WR_IDLE or WR_BEAT1 to WR_ADDR when a write is commanded, and to WR_IDLE otherwise. It always goes from WR_ADDR to WR_BEAT1 on the K# edge that follows. The first word is stored in WR_ADDR and the second in WR_BEAT1.

Top module: `qdr_b2_sram`

## Requirements
- R1: While reset is held and right after its release, `rdata_oe` is 0, `rdata` is 0, `echo` is 0 and `k_phase` is 1.
- R2: A read is accepted when `rd_n` is 0 at K edge t, and the address is taken on that edge. The word at the address with bit 0 cleared is driven with `rdata_oe`=1 from edge t+2 until edge t+3. The word with bit 0 set is driven from edge t+3 until edge t+4.
- R3: Bit 0 of the read address has no effect on a burst: an odd address returns its even partner first, then itself.
- R4: Reads accepted on consecutive K edges give an unbroken stream of words with `rdata_oe` held high.
- R5: When `rd_n` is 1 at a K edge, the burst already in flight still completes. After that, `rdata_oe` falls and `rdata` reads 0.
- R6: A write is accepted when `wr_n` is 0 at K edge t. Word 0 and its byte enables are taken at t. The address, word 1 and its byte enables are taken at K# edge t+1. The two words go to the address with bit 0 cleared and then with bit 0 set.
- R7: `byte_en_n` is active low. Lane i gates bits 9i to 9i+8 of a word, so lane 0 covers bits 0..8 and lane 3 covers bits 27..35. Bits of a disabled lane keep their stored value.
- R8: Write data and byte enables present at a K edge where `wr_n` is 1 change no stored word.
- R9: A read and a write may be accepted on the same K edge. A read returns the data of every write accepted on the same K edge or an earlier one. It does not return the data of a write accepted on a later K edge.
- R10: `echo` is 1 while the first word of a burst is driven and 0 while the second is driven or the read port is deselected.
- R11: Writes accepted on consecutive K edges are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is a K or a K# edge |
| rst_n | input | 1 | Active-low synchronous reset |
| k_phase | output | 1 | 1 when the coming clk edge is a K edge |
| addr | input | ADDR_W | Shared address: read address on K edges, write address on K# edges |
| rd_n | input | 1 | Active-low read select, sampled on K edges |
| wr_n | input | 1 | Active-low write select, sampled on K edges |
| byte_en_n | input | DATA_W/LANE_W | Active-low lane write enables, sampled with each write word |
| wdata | input | DATA_W | Write data: word 0 on K edge, word 1 on K# edge |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High while rdata carries a valid read word |
| echo | output | 1 | High on the first read word of a burst |

## Verification
Some properties are checked on every cycle by the assertions. They cover the phase placement of the first-beat and address states, the fixed step from the first beat to the second on both ports, the two-edge read latency, deselect after a K edge without a read, and the return of the write machine to idle when no write is commanded. Other behaviour can only be shown by the bench's scenarios against its reference memory. This covers the data values themselves, the effect of byte lanes, the ignored data when no write is commanded, and the ordering of reads and writes on the same address. It also covers the lack of gaps in back-to-back bursts and the echo level on each beat.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

    typedef enum logic [1:0] {
        RD_DESEL = 2'd0,
        RD_BEAT0 = 2'd1,
        RD_BEAT1 = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_ADDR  = 2'd1,
        WR_BEAT1 = 2'd2
    } wr_state_e;

endpackage

// File: rtl/qdr_b2_mem.sv
module qdr_b2_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANE_W = 9
) (
    input  logic                       clk,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rword,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wword,
    input  logic [DATA_W/LANE_W-1:0]   wlane
);
    localparam int NLANE = DATA_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    // one storage bank per byte lane, so each lane has its own write enable
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wlane[g]) begin
                bank[waddr] <= wword[g*LANE_W +: LANE_W];
            end
        end

        assign rword[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/qdr_b2_rd_ctrl.sv
module qdr_b2_rd_ctrl
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_edge,
    input  logic              rd_n,
    input  logic [ADDR_W-2:0] burst_addr,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              echo
);
    rd_state_e         state_q, state_d;
    logic              pend_q;
    logic [ADDR_W-2:0] base_q;
    logic [ADDR_W-2:0] out_base_q;
    logic [DATA_W-1:0] data_q;

    // command capture: K edges only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            base_q <= '0;
        end else if (k_edge) begin
            pend_q <= ~rd_n;
            if (!rd_n) begin
                base_q <= burst_addr;
            end
        end
    end

    // next-state logic of the output machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_DESEL, RD_BEAT1: state_d = (k_edge && pend_q) ? RD_BEAT0 : RD_DESEL;
            RD_BEAT0:           state_d = RD_BEAT1;
            default:            state_d = RD_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // output pipeline: base of the burst on the port, then data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_base_q <= '0;
            data_q     <= '0;
        end else begin
            if (state_d == RD_BEAT0) begin
                out_base_q <= base_q;
            end
            if (state_d != RD_DESEL) begin
                data_q <= mem_q;
            end
        end
    end

    // first word fetched on the K edge, second on the K# edge
    assign mem_raddr = k_edge ? {base_q, 1'b0} : {out_base_q, 1'b1};

    // outputs decoded from state
    always_comb begin
        rdata_oe = 1'b0;
        echo     = 1'b0;
        rdata    = '0;
        unique case (state_q)
            RD_DESEL: ;
            RD_BEAT0: begin
                rdata_oe = 1'b1;
                echo     = 1'b1;
                rdata    = data_q;
            end
            RD_BEAT1: begin
                rdata_oe = 1'b1;
                rdata    = data_q;
            end
            default: ;
        endcase
    end

    p_beat0_khalf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_BEAT0) |-> !k_edge);

    p_beat1_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_BEAT0) |=> (state_q == RD_BEAT1));

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (k_edge && !rd_n) |=> ##2 (state_q == RD_BEAT0));

    p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_edge && rd_n) |=> ##2 !rdata_oe);

endmodule

// File: rtl/qdr_b2_wr_ctrl.sv
module qdr_b2_wr_ctrl
    import qdr_b2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int NLANE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_edge,
    input  logic              wr_n,
    input  logic [ADDR_W-2:0] burst_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NLANE-1:0]  byte_en_n,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wword,
    output logic [NLANE-1:0]  mem_wlane
);
    wr_state_e         state_q, state_d;
    logic [ADDR_W-2:0] base_q;
    logic [DATA_W-1:0] word0_q, word1_q;
    logic [NLANE-1:0]  lane0_q, lane1_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE, WR_BEAT1: state_d = (k_edge && !wr_n) ? WR_ADDR : WR_IDLE;
            WR_ADDR:           state_d = WR_BEAT1;
            default:           state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // early data capture on the command edge, address and word 1 on K#
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0_q <= '0;
            lane0_q <= '0;
            word1_q <= '0;
            lane1_q <= '0;
            base_q  <= '0;
        end else begin
            if (k_edge && !wr_n) begin
                word0_q <= wdata;
                lane0_q <= ~byte_en_n;
            end
            if (state_q == WR_ADDR) begin
                base_q  <= burst_addr;
                word1_q <= wdata;
                lane1_q <= ~byte_en_n;
            end
        end
    end

    // one commit per edge: word 0 on K#, word 1 on the next K
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wword = '0;
        mem_wlane = '0;
        unique case (state_q)
            WR_IDLE: ;
            WR_ADDR: begin
                mem_we    = 1'b1;
                mem_waddr = {burst_addr, 1'b0};
                mem_wword = word0_q;
                mem_wlane = lane0_q;
            end
            WR_BEAT1: begin
                mem_we    = 1'b1;
                mem_waddr = {base_q, 1'b1};
                mem_wword = word1_q;
                mem_wlane = lane1_q;
            end
            default: ;
        endcase
    end

    p_addr_khalf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_ADDR) |-> !k_edge);

    p_addr_then_beat1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_ADDR) |=> (state_q == WR_BEAT1));

    p_idle_no_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (k_edge && wr_n) |=> (state_q == WR_IDLE));

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     k_phase,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [DATA_W/LANE_W-1:0] byte_en_n,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_oe,
    output logic                     echo
);
    localparam int NLANE = DATA_W / LANE_W;

    logic              k_edge_q;
    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic [DATA_W-1:0] mem_q, mem_wword;
    logic [NLANE-1:0]  mem_wlane;
    logic              mem_we;
    logic              unused_addr_lsb;

    assign unused_addr_lsb = addr[0];

    // phase of the double-rate clock: first edge after reset is a K edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_edge_q <= 1'b1;
        end else begin
            k_edge_q <= ~k_edge_q;
        end
    end
    assign k_phase = k_edge_q;

    qdr_b2_rd_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .k_edge     (k_edge_q),
        .rd_n       (rd_n),
        .burst_addr (addr[ADDR_W-1:1]),
        .mem_q      (mem_q),
        .mem_raddr  (mem_raddr),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe),
        .echo       (echo)
    );

    qdr_b2_wr_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NLANE  (NLANE)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .k_edge     (k_edge_q),
        .wr_n       (wr_n),
        .burst_addr (addr[ADDR_W-1:1]),
        .wdata      (wdata),
        .byte_en_n  (byte_en_n),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wword  (mem_wword),
        .mem_wlane  (mem_wlane)
    );

    qdr_b2_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk   (clk),
        .raddr (mem_raddr),
        .rword (mem_q),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wword (mem_wword),
        .wlane (mem_wlane)
    );

    p_phase_alternates_r1: assert property (@(posedge clk) disable iff (!rst_n)
        k_phase |=> !k_phase);

    p_echo_needs_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        echo |=> (rdata_oe && !echo));

endmodule

// File: tb/qdr_b2_sram_tb.sv
module qdr_b2_sram_tb;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_phase;
    logic [AW-1:0] addr = '0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [NL-1:0] byte_en_n = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    logic          echo;

    qdr_b2_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .byte_en_n(byte_en_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .echo(echo)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            due;
        logic [DW-1:0] word;
        bit            first;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] model [1 << AW];
    int            ecnt = 0;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return {9'(9'h100 + k), 9'(9'h080 + k), 9'(9'h040 + k), 9'(9'h020 + k)};
    endfunction

    function automatic void model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                     input logic [NL-1:0] en);
        for (int i = 0; i < NL; i++) begin
            if (en[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
        end
    endfunction

    // driver: one K cycle (a K edge then a K# edge); call at a negedge with k_phase high
    task automatic kcycle(input bit rd, input logic [AW-1:0] ra, input bit wr,
                          input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                          input logic [NL-1:0] en0, input logic [DW-1:0] d1,
                          input logic [NL-1:0] en1, input string tag);
        int cmd_edge;
        while (!k_phase) @(negedge clk);
        cmd_edge = ecnt + 1;
        rd_n = ~rd; wr_n = ~wr; addr = ra; wdata = d0; byte_en_n = ~en0;
        if (wr) begin
            model_wr({wa[AW-1:1], 1'b0}, d0, en0);
            model_wr({wa[AW-1:1], 1'b1}, d1, en1);
        end
        if (rd) begin
            q.push_back('{cmd_edge + 2, model[{ra[AW-1:1], 1'b0}], 1'b1, tag});
            q.push_back('{cmd_edge + 3, model[{ra[AW-1:1], 1'b1}], 1'b0, tag});
        end
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; addr = wa; wdata = d1; byte_en_n = ~en1;
        @(negedge clk);
        wdata = '0; byte_en_n = '1; addr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) kcycle(0, 0, 0, 0, '0, '0, '0, '0, "idle");
    endtask

    // monitor: compares each output beat in its due cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == ecnt) begin
                check(rdata_oe === 1'b1 && rdata === q[0].word, q[0].tag, rdata, q[0].word);
                check(echo === q[0].first, "R10 echo", {35'd0, echo}, {35'd0, q[0].first});
                void'(q.pop_front());
            end else if (rdata_oe !== 1'b0) begin
                check(1'b0, "R5 unexpected rdata_oe", rdata, '0);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        repeat (4) @(negedge clk);
        check(rdata_oe === 1'b0 && rdata === '0 && echo === 1'b0, "R1 in reset", rdata, '0);
        rst_n = 1'b1;
        check(k_phase === 1'b1, "R1 phase", {35'd0, k_phase}, 36'd1);
        check(rdata_oe === 1'b0 && echo === 1'b0, "R1 after release", rdata, '0);

        // R11 and R6: back-to-back full writes fill addresses 0..7
        for (int a = 0; a < 8; a += 2)
            kcycle(0, 0, 1, 6'(a), pat(a), 4'hF, pat(a + 1), 4'hF, "R11");
        idle(1);

        // R2: single read
        kcycle(1, 6'd2, 0, 0, '0, '0, '0, '0, "R2 single read");
        idle(3);
        check(rdata_oe === 1'b0 && rdata === '0 && echo === 1'b0, "R5 deselect", rdata, '0);

        // R3: odd address gives even partner first
        kcycle(1, 6'd5, 0, 0, '0, '0, '0, '0, "R3 odd address");
        idle(2);

        // R4: consecutive reads
        for (int a = 0; a < 8; a += 2)
            kcycle(1, 6'(a), 0, 0, '0, '0, '0, '0, "R4 back-to-back");
        idle(2);
        check(rdata_oe === 1'b0 && rdata === '0, "R5 after stream", rdata, '0);

        // R7: byte lanes
        kcycle(0, 0, 1, 6'd2, 36'hF_FFFF_FFFF, 4'b0101, 36'h0_0000_0000, 4'b1000, "R7");
        kcycle(1, 6'd2, 0, 0, '0, '0, '0, '0, "R7 lane mask");
        idle(2);

        // R8: data without write select is ignored
        kcycle(0, 0, 0, 6'd4, 36'h5_5555_5555, 4'hF, 36'hA_AAAA_AAAA, 4'hF, "R8");
        kcycle(1, 6'd4, 0, 0, '0, '0, '0, '0, "R8 ignored data");
        idle(2);

        // R9: read and write on the same edge, same address
        kcycle(1, 6'd6, 1, 6'd6, 36'h1_2345_6789, 4'hF, 36'h9_8765_4321, 4'b0011, "R9 same edge");
        // R9: read then a later write: read keeps old data
        kcycle(1, 6'd0, 0, 0, '0, '0, '0, '0, "R9 read before write");
        kcycle(0, 0, 1, 6'd0, 36'hC_0FFE_E000, 4'hF, 36'hB_EEF0_0001, 4'hF, "R9");
        kcycle(1, 6'd0, 1, 6'd2, 36'h7_7777_7777, 4'hF, 36'h3_3333_3333, 4'hF, "R9 after write");
        kcycle(1, 6'd2, 0, 0, '0, '0, '0, '0, "R9 different address");
        idle(3);

        check(q.size() == 0, "R2 all beats seen", 36'(q.size()), '0);
        check(rdata_oe === 1'b0 && echo === 1'b0, "R10 deselect echo", {35'd0, echo}, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule